// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and the two integer execution pipes, U and V, of an in-order core. Each cycle it receives two decoded instruction descriptors in program order: an older one (slot A) and a younger one (slot B). Each descriptor gives the instruction kind, three prefix flags, the memory access kind, a flag for an immediate combined with a displacement, two constant-operand flags, and the registers the instruction reads and writes.

Each instruction is sorted into one of four pairing classes. The block then decides whether the pair can go out together, with A in U and B in V, or whether only A goes out, in U. The issue decision and both class codes are registered and appear one clock after the descriptors are presented.

Top module: `pair_issue`

## Requirements
- R1: While `rst` is high, and in the cycle after it was high, `issue_u` and `issue_v` are 0 and both class outputs are 2'b11.
- R2: Class codes are 2'b00 (either pipe), 2'b01 (U only), 2'b10 (V only) and 2'b11 (not pairable). A descriptor with `immdisp` set is classed 2'b11 whatever its kind.
- R3: Kinds 0 (ALU), 1 (move), 2 (compare), 3 (test), 4 (address computation) and 5 (increment/decrement) are classed 2'b00. Kinds 6 (push) and 7 (pop) are also 2'b00 unless the memory kind is 3 (read-modify-write), in which case they are 2'b11. Memory kind encoding: 0 none, 1 load, 2 store, 3 read-modify-write.
- R4: If any prefix bit is set ([0] two-byte opcode escape, [1] 16-bit operand size, [2] repeat), a kind that R3 would class 2'b00 is classed 2'b01.
- R5: Kind 8 (branch) is classed 2'b10. Kind 9 (call) is classed 2'b10 when `cnst` is set (constant target), otherwise 2'b11.
- R6: Kind 10 (shift) is classed 2'b01 when `cnst` is set (constant count), otherwise 2'b11. Kind 11 (rotate) is classed 2'b01 when `one` is set (count of exactly one), otherwise 2'b11.
- R7: Kinds 12 to 15 are classed 2'b11.
- R8: With `in_valid` high, both issue outputs are 1 when slot A's class is 2'b00 or 2'b01, slot B's class is 2'b00 or 2'b10, and no register hazard exists (R9). Otherwise `issue_u` is 1 and `issue_v` is 0.
- R9: A register hazard exists when B writes register `b_wr_reg` (`b_wr_en` high) and either bit `b_wr_reg` of `a_rd_mask` is set or A writes that same register. A hazard forces `issue_v` to 0.
- R10: With `in_valid` low, `issue_u` and `issue_v` are 0 in the next cycle; the class outputs still follow the descriptors.
- R11: `issue_v` is never 1 while `issue_u` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor pair present |
| a_kind | input | 4 | Older instruction kind |
| a_pfx | input | 3 | Older prefix flags |
| a_mem | input | 2 | Older memory access kind |
| a_immdisp | input | 1 | Older has immediate and displacement |
| a_cnst | input | 1 | Older constant count or constant call target |
| a_one | input | 1 | Older rotate count is one |
| a_rd_mask | input | NREG | Registers read by older |
| a_wr_en | input | 1 | Older writes a register |
| a_wr_reg | input | $clog2(NREG) | Register written by older |
| b_kind | input | 4 | Younger instruction kind |
| b_pfx | input | 3 | Younger prefix flags |
| b_mem | input | 2 | Younger memory access kind |
| b_immdisp | input | 1 | Younger has immediate and displacement |
| b_cnst | input | 1 | Younger constant count or constant call target |
| b_one | input | 1 | Younger rotate count is one |
| b_wr_en | input | 1 | Younger writes a register |
| b_wr_reg | input | $clog2(NREG) | Register written by younger |
| issue_u | output | 1 | Older instruction issues to U |
| issue_v | output | 1 | Younger instruction issues to V |
| cls_u | output | 2 | Pairing class of older |
| cls_v | output | 2 | Pairing class of younger |

## Verification
Every result of this block, both issue bits and both class codes, is due exactly one rising edge after the descriptors it depends on. The bench changes descriptors on the falling edge, lets one rising edge capture them, and compares all four outputs at the following falling edge before driving the next pair, so each comparison sees the outputs for the pair driven one cycle earlier. Reset is checked the same way, including a pairable pair held on the inputs while reset is high.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int KIND_W = 4;
  localparam int PFX_W  = 3;
  localparam int MEM_W  = 2;

  typedef enum logic [1:0] {
    PC_UV = 2'b00,
    PC_U  = 2'b01,
    PC_V  = 2'b10,
    PC_NP = 2'b11
  } pcls_t;

  localparam logic [KIND_W-1:0] K_INCDEC = 4'd5;
  localparam logic [KIND_W-1:0] K_PUSH   = 4'd6;
  localparam logic [KIND_W-1:0] K_POP    = 4'd7;
  localparam logic [KIND_W-1:0] K_BRANCH = 4'd8;
  localparam logic [KIND_W-1:0] K_CALL   = 4'd9;
  localparam logic [KIND_W-1:0] K_SHIFT  = 4'd10;
  localparam logic [KIND_W-1:0] K_ROTATE = 4'd11;

  localparam logic [MEM_W-1:0] M_RMW = 2'd3;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [PFX_W-1:0]  pfx;
    logic [MEM_W-1:0]  mem;
    logic              immdisp;
    logic              cnst;
    logic              one;
  } desc_t;
endpackage

// File: rtl/pair_classify.sv
module pair_classify
  import pair_pkg::*;
(
  input  desc_t       d,
  output logic [1:0]  cls
);
  logic simple_k;
  logic stack_k;

  always_comb begin
    simple_k = (d.kind <= K_INCDEC);
    stack_k  = ((d.kind == K_PUSH) || (d.kind == K_POP)) && (d.mem != M_RMW);
    cls = PC_NP;
    if (d.immdisp)
      cls = PC_NP;
    else if (simple_k || stack_k)
      cls = (|d.pfx) ? PC_U : PC_UV;
    else if (d.kind == K_BRANCH)
      cls = PC_V;
    else if ((d.kind == K_CALL) && d.cnst)
      cls = PC_V;
    else if ((d.kind == K_SHIFT) && d.cnst)
      cls = PC_U;
    else if ((d.kind == K_ROTATE) && d.one)
      cls = PC_U;
  end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic [NREG-1:0] a_rd_mask,
  input  logic            a_wr_en,
  input  logic [RW-1:0]   a_wr_reg,
  input  logic            b_wr_en,
  input  logic [RW-1:0]   b_wr_reg,
  output logic            hazard
);
  logic raw_hit;
  logic waw_hit;

  always_comb begin
    raw_hit = a_rd_mask[b_wr_reg];
    waw_hit = a_wr_en && (a_wr_reg == b_wr_reg);
    hazard  = b_wr_en && (raw_hit || waw_hit);
  end
endmodule

// File: rtl/pair_issue.sv
module pair_issue
  import pair_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [KIND_W-1:0]   a_kind,
  input  logic [PFX_W-1:0]    a_pfx,
  input  logic [MEM_W-1:0]    a_mem,
  input  logic                a_immdisp,
  input  logic                a_cnst,
  input  logic                a_one,
  input  logic [NREG-1:0]     a_rd_mask,
  input  logic                a_wr_en,
  input  logic [RW-1:0]       a_wr_reg,
  input  logic [KIND_W-1:0]   b_kind,
  input  logic [PFX_W-1:0]    b_pfx,
  input  logic [MEM_W-1:0]    b_mem,
  input  logic                b_immdisp,
  input  logic                b_cnst,
  input  logic                b_one,
  input  logic                b_wr_en,
  input  logic [RW-1:0]       b_wr_reg,
  output logic                issue_u,
  output logic                issue_v,
  output logic [1:0]          cls_u,
  output logic [1:0]          cls_v
);
  localparam int NSLOT = 2;

  desc_t      slot_d   [NSLOT];
  logic [1:0] slot_cls [NSLOT];
  logic       hazard;
  logic       u_ok;
  logic       v_ok;
  logic       dual;

  always_comb begin
    slot_d[0] = '{kind: a_kind, pfx: a_pfx, mem: a_mem,
                  immdisp: a_immdisp, cnst: a_cnst, one: a_one};
    slot_d[1] = '{kind: b_kind, pfx: b_pfx, mem: b_mem,
                  immdisp: b_immdisp, cnst: b_cnst, one: b_one};
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_cls
    pair_classify u_cls (
      .d   (slot_d[s]),
      .cls (slot_cls[s])
    );
  end

  pair_hazard #(.NREG(NREG)) u_haz (
    .a_rd_mask (a_rd_mask),
    .a_wr_en   (a_wr_en),
    .a_wr_reg  (a_wr_reg),
    .b_wr_en   (b_wr_en),
    .b_wr_reg  (b_wr_reg),
    .hazard    (hazard)
  );

  always_comb begin
    u_ok = (slot_cls[0] == PC_UV) || (slot_cls[0] == PC_U);
    v_ok = (slot_cls[1] == PC_UV) || (slot_cls[1] == PC_V);
    dual = in_valid && u_ok && v_ok && !hazard;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_u <= 1'b0;
      issue_v <= 1'b0;
      cls_u   <= PC_NP;
      cls_v   <= PC_NP;
    end else begin
      issue_u <= in_valid;
      issue_v <= dual;
      cls_u   <= slot_cls[0];
      cls_v   <= slot_cls[1];
    end
  end
endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk #(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          a_immdisp,
  input logic          b_immdisp,
  input logic          a_wr_en,
  input logic [RW-1:0] a_wr_reg,
  input logic          b_wr_en,
  input logic [RW-1:0] b_wr_reg,
  input logic          issue_u,
  input logic          issue_v,
  input logic [1:0]    cls_u,
  input logic [1:0]    cls_v
);
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!issue_u && !issue_v && cls_u == 2'b11 && cls_v == 2'b11)); // R1

  AST_IMMDISP_NP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_immdisp)) |-> (cls_u == 2'b11 && !issue_v)); // R2

  AST_IMMDISP_YOUNG: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(b_immdisp)) |-> (cls_v == 2'b11 && !issue_v)); // R2

  AST_PAIR_CLASSES: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> ((cls_u == 2'b00 || cls_u == 2'b01) &&
                 (cls_v == 2'b00 || cls_v == 2'b10))); // R8

  AST_WAW_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(b_wr_en && a_wr_en && (a_wr_reg == b_wr_reg)))
      |-> !issue_v); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> (!issue_u && !issue_v)); // R10

  AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (rst)
    issue_v |-> issue_u); // R11
endmodule

bind pair_issue pair_issue_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a_immdisp (a_immdisp),
  .b_immdisp (b_immdisp),
  .a_wr_en   (a_wr_en),
  .a_wr_reg  (a_wr_reg),
  .b_wr_en   (b_wr_en),
  .b_wr_reg  (b_wr_reg),
  .issue_u   (issue_u),
  .issue_v   (issue_v),
  .cls_u     (cls_u),
  .cls_v     (cls_v)
);

// File: tb/sim_pair_issue.sv
`timescale 1ns/1ps
module sim_pair_issue;
  localparam int NREG = 8;
  localparam int RW = $clog2(NREG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] a_kind = '0, b_kind = '0;
  logic [2:0] a_pfx = '0, b_pfx = '0;
  logic [1:0] a_mem = '0, b_mem = '0;
  logic a_immdisp = 1'b0, b_immdisp = 1'b0;
  logic a_cnst = 1'b0, b_cnst = 1'b0, a_one = 1'b0, b_one = 1'b0;
  logic [NREG-1:0] a_rd_mask = '0;
  logic a_wr_en = 1'b0, b_wr_en = 1'b0;
  logic [RW-1:0] a_wr_reg = '0, b_wr_reg = '0;
  logic issue_u, issue_v;
  logic [1:0] cls_u, cls_v;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pair_issue #(.NREG(NREG)) u0 (.*);

  function automatic logic [1:0] model_cls(input logic [3:0] k, input logic [2:0] p,
      input logic [1:0] m, input logic id, input logic c, input logic o);
    if (id) return 2'b11;                                        // R2
    if (k <= 4'd5 || ((k == 4'd6 || k == 4'd7) && m != 2'd3))
      return (p != 3'b000) ? 2'b01 : 2'b00;                      // R3 R4
    if (k == 4'd8) return 2'b10;                                 // R5
    if (k == 4'd9) return c ? 2'b10 : 2'b11;                     // R5
    if (k == 4'd10) return c ? 2'b01 : 2'b11;                    // R6
    if (k == 4'd11) return o ? 2'b01 : 2'b11;                    // R6
    return 2'b11;                                                // R7
  endfunction

  function automatic string cls_tag(input logic [3:0] k, input logic [2:0] p,
      input logic id);
    if (id) return "R2";
    if (k <= 4'd7) return (p != 3'b000 && k <= 4'd7) ? "R4" : "R3";
    if (k <= 4'd9) return "R5";
    if (k <= 4'd11) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_a(input logic [3:0] k, input logic [2:0] p, input logic [1:0] m,
      input logic id, input logic c, input logic o);
    a_kind = k; a_pfx = p; a_mem = m; a_immdisp = id; a_cnst = c; a_one = o;
  endtask

  task automatic set_b(input logic [3:0] k, input logic [2:0] p, input logic [1:0] m,
      input logic id, input logic c, input logic o);
    b_kind = k; b_pfx = p; b_mem = m; b_immdisp = id; b_cnst = c; b_one = o;
  endtask

  task automatic set_regs(input logic [NREG-1:0] rm, input logic aw, input logic [RW-1:0] ar,
      input logic bw, input logic [RW-1:0] br);
    a_rd_mask = rm; a_wr_en = aw; a_wr_reg = ar; b_wr_en = bw; b_wr_reg = br;
  endtask

  // Inputs are already driven at a falling edge; one rising edge captures,
  // results are compared at the next falling edge.
  task automatic step_check();
    logic [1:0] eu, ev;
    logic haz, dual;
    string tu, tv, td;
    eu = model_cls(a_kind, a_pfx, a_mem, a_immdisp, a_cnst, a_one);
    ev = model_cls(b_kind, b_pfx, b_mem, b_immdisp, b_cnst, b_one);
    tu = cls_tag(a_kind, a_pfx, a_immdisp);
    tv = cls_tag(b_kind, b_pfx, b_immdisp);
    haz = b_wr_en && (a_rd_mask[b_wr_reg] || (a_wr_en && a_wr_reg == b_wr_reg));
    dual = in_valid && (eu == 2'b00 || eu == 2'b01) && (ev == 2'b00 || ev == 2'b10) && !haz;
    td = !in_valid ? "R10" : (haz ? "R9" : "R8");
    @(posedge clk);
    @(negedge clk);
    chk(tu, "cls_u", cls_u, eu);
    chk(tv, "cls_v", cls_v, ev);
    chk(td, "issue_u", issue_u, in_valid);
    chk(td, "issue_v", issue_v, dual);
    if (issue_v && !issue_u) chk("R11", "v without u", 1, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset values, even with a pairable pair on the inputs
    in_valid = 1'b1;
    set_a(4'd0, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    set_b(4'd1, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1", "issue_u in reset", issue_u, 0);
    chk("R1", "issue_v in reset", issue_v, 0);
    chk("R1", "cls_u in reset", cls_u, 3);
    chk("R1", "cls_v in reset", cls_v, 3);
    rst = 1'b0;

    // R8: simple + simple dual issue
    set_regs('0, 1'b1, 3'd1, 1'b1, 3'd2);
    step_check();
    // R2: imm+disp on younger blocks pairing
    set_b(4'd0, 3'b000, 2'd0, 1'b1, 1'b0, 1'b0);
    step_check();
    // R4: prefixed older in U, branch in V -> dual
    set_a(4'd2, 3'b100, 2'd0, 1'b0, 1'b0, 1'b0);
    set_b(4'd8, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    set_regs('0, 1'b0, 3'd0, 1'b0, 3'd0);
    step_check();
    // R4: prefixed younger is U-only -> single
    set_a(4'd0, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    set_b(4'd5, 3'b010, 2'd0, 1'b0, 1'b0, 1'b0);
    step_check();
    // R3: push with read-modify-write not pairable
    set_a(4'd6, 3'b000, 2'd3, 1'b0, 1'b0, 1'b0);
    set_b(4'd7, 3'b000, 2'd1, 1'b0, 1'b0, 1'b0);
    step_check();
    // R5: branch as older cannot take U
    set_a(4'd8, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    set_b(4'd0, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    step_check();
    // R5 R6: constant shift in U, constant call in V
    set_a(4'd10, 3'b000, 2'd0, 1'b0, 1'b1, 1'b0);
    set_b(4'd9, 3'b000, 2'd0, 1'b0, 1'b1, 1'b0);
    step_check();
    // R6: rotate by one with variable shift
    set_a(4'd11, 3'b000, 2'd0, 1'b0, 1'b0, 1'b1);
    set_b(4'd10, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    step_check();
    // R7: other kinds
    set_a(4'd12, 3'b000, 2'd0, 1'b0, 1'b1, 1'b1);
    set_b(4'd15, 3'b000, 2'd0, 1'b0, 1'b1, 1'b1);
    step_check();
    // R9: younger writes register older reads
    set_a(4'd0, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    set_b(4'd1, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0);
    set_regs(8'b0001_0000, 1'b1, 3'd2, 1'b1, 3'd4);
    step_check();
    // R9: younger writes register older writes
    set_regs(8'b0000_0001, 1'b1, 3'd6, 1'b1, 3'd6);
    step_check();
    // R9: same register but younger does not write -> dual
    set_regs(8'b0100_0000, 1'b1, 3'd6, 1'b0, 3'd6);
    step_check();
    // R10: no valid pair
    in_valid = 1'b0;
    step_check();
    in_valid = 1'b1;

    for (int i = 0; i < 3000; i++) begin
      in_valid = ($urandom_range(0, 7) != 0);
      set_a(4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
            2'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom));
      set_b(4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
            2'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom));
      set_regs(NREG'($urandom) & NREG'($urandom), 1'($urandom), RW'($urandom),
               1'($urandom), RW'($urandom));
      step_check();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule